// File: doc/BRIEF.md
# Virtual-8086 Trapped Instruction Emulation Sequencer

This block performs in hardware the work a monitor does after a virtual-8086 task traps on a sensitive instruction. A saved frame (stack segment, stack pointer, 32-bit flags image, code segment and instruction pointer) is loaded with a start pulse, together with a class code for the trapped instruction and, for software interrupts, the interrupt number. The sequencer then edits the frame and, where the class needs it, reads or writes 16-bit words on the user stack or in the real-mode vector table through a single request/acknowledge memory port.

When the frame is final the block raises `done_o` for one cycle. The updated frame is presented on its outputs for the caller to resume the task with. For a halt the same pulse comes with `term_o`, telling the caller to end the task instead of resuming it. Fetching the opcode and the return to user mode itself stay outside the block.

Top module: `v86_emu_seq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `term_o` and `mem_req_o` are low and the frame outputs are zero.
- R2: Class code 0 clears and class code 1 sets bit 9 of the flags image, leaves every other flag bit alone, adds 1 to IP and makes no memory access.
- R3: Class code 2 subtracts 2 from SP, writes flags bits 15:0 to the new stack top and adds 1 to IP.
- R4: Class code 3 reads the word at the stack top into flags bits 15:0, keeps bits 31:16, adds 2 to SP and adds 1 to IP.
- R5: Class code 4 adds 2 to IP, then writes flags bits 15:0, CS and the advanced IP to the three words below SP in that order (each at a lower address), leaving SP reduced by 6.
- R6: Class code 4 then reads the new IP from interrupt number × 4 and the new CS from interrupt number × 4 + 2, and clears flags bits 9 and 8.
- R7: Class code 5 reads IP, CS and flags from SP, SP+2 and SP+4 in that order and adds 6 to SP; flags bits 31:16 and the privilege field in bits 13:12 keep their old values.
- R8: Class code 6 pulses `term_o` together with `done_o` with the frame unchanged and no memory access; class code 7 pulses `done_o` alone with the frame unchanged.
- R9: A stack address is SS × 16 plus the 16-bit offset, where the offset wraps modulo 2^16 and the sum is truncated to 20 bits.
- R10: A request holds its address, direction and write data until acknowledged; each acknowledge completes exactly one access.
- R11: `busy_o` is high from the cycle after start through the `done_o` cycle; `done_o` lasts one cycle and follows the last frame update.
- R12: A start pulse while `busy_o` is high, including in the `done_o` cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an emulation when idle |
| op_i | input | 3 | Class code of the trapped instruction |
| vec_i | input | 8 | Interrupt number for class 4 |
| ss_i | input | 16 | Saved stack segment |
| sp_i | input | 16 | Saved stack pointer |
| flags_i | input | 32 | Saved flags image |
| cs_i | input | 16 | Saved code segment |
| ip_i | input | 16 | Saved instruction pointer |
| busy_o | output | 1 | Emulation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| term_o | output | 1 | Task should end (with done) |
| sp_o | output | 16 | Updated stack pointer |
| flags_o | output | 32 | Updated flags image |
| cs_o | output | 16 | Updated code segment |
| ip_o | output | 16 | Updated instruction pointer |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 20 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access acknowledge |

## Verification
Two events can meet at one clock edge: a new start pulse and the tail of a running emulation, either a memory acknowledge in mid-sequence or the completion cycle itself. The bench provokes both by holding start high, with a different class code and different frame inputs, during the run and again in the `done_o` cycle. It judges the result by the frame matching the first emulation's model, no memory access appearing beyond the expected list, and `busy_o` and `done_o` falling the cycle after the pulse. Acknowledge latencies of zero to two cycles make stack-pointer updates coincide with back-to-back accesses.

// File: rtl/v86_emu_pkg.sv
package v86_emu_pkg;
  typedef enum logic [2:0] {
    OP_CLI   = 3'd0,
    OP_STI   = 3'd1,
    OP_PUSHF = 3'd2,
    OP_POPF  = 3'd3,
    OP_INT   = 3'd4,
    OP_IRET  = 3'd5,
    OP_HLT   = 3'd6,
    OP_NONE  = 3'd7
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_e;

  typedef enum logic [2:0] {
    FX_HOLD, FX_CLR_IF, FX_SET_IF, FX_LOAD_LO, FX_LOAD_USER, FX_ENTER_INT
  } fx_e;

  localparam int unsigned IF_BIT  = 9;
  localparam int unsigned TF_BIT  = 8;
  localparam int unsigned IOPL_LO = 12;
  localparam int unsigned IOPL_HI = 13;
endpackage

// File: rtl/v86_emu_agen.sv
module v86_emu_agen #(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16,
  parameter int unsigned VW = 8
) (
  input  logic [DW-1:0] seg_i,
  input  logic [DW-1:0] off_i,
  input  logic [VW-1:0] vec_i,
  input  logic          vsel_i,
  input  logic          vhi_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] stk_addr, vec_addr;

  // paragraph-scaled segment plus offset, carry past AW dropped
  assign stk_addr = AW'({seg_i, 4'b0000}) + AW'(off_i);
  assign vec_addr = AW'({vec_i, 2'b00}) + AW'({vhi_i, 1'b0});
  assign addr_o   = vsel_i ? vec_addr : stk_addr;
endmodule

// File: rtl/v86_emu_flagfix.sv
module v86_emu_flagfix
  import v86_emu_pkg::*;
#(
  parameter int unsigned FW = 32,
  parameter int unsigned DW = 16
) (
  input  fx_e           mode_i,
  input  logic [FW-1:0] flags_i,
  input  logic [DW-1:0] word_i,
  output logic [FW-1:0] flags_o
);
  always_comb begin
    flags_o = flags_i;
    unique case (mode_i)
      FX_CLR_IF:    flags_o[IF_BIT] = 1'b0;
      FX_SET_IF:    flags_o[IF_BIT] = 1'b1;
      FX_LOAD_LO:   flags_o[DW-1:0] = word_i;
      FX_LOAD_USER: begin
        flags_o[DW-1:0]          = word_i;
        flags_o[IOPL_HI:IOPL_LO] = flags_i[IOPL_HI:IOPL_LO];
      end
      FX_ENTER_INT: begin
        flags_o[IF_BIT] = 1'b0;
        flags_o[TF_BIT] = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/v86_emu_seq.sv
module v86_emu_seq
  import v86_emu_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16,
  parameter int unsigned FW = 32,
  parameter int unsigned VW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [VW-1:0] vec_i,
  input  logic [DW-1:0] ss_i,
  input  logic [DW-1:0] sp_i,
  input  logic [FW-1:0] flags_i,
  input  logic [DW-1:0] cs_i,
  input  logic [DW-1:0] ip_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          term_o,
  output logic [DW-1:0] sp_o,
  output logic [FW-1:0] flags_o,
  output logic [DW-1:0] cs_o,
  output logic [DW-1:0] ip_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i
);
  localparam int unsigned STEP_W = 3;
  localparam logic [DW-1:0] ONE = DW'(1);
  localparam logic [DW-1:0] TWO = DW'(2);

  st_e              st_q;
  op_e              op_q;
  logic [VW-1:0]    vec_q;
  logic [STEP_W-1:0] step_q;
  logic [DW-1:0]    ss_q, sp_q, cs_q, ip_q;
  logic [FW-1:0]    flags_q, flags_nxt;

  logic acc_rd, acc_wr, off_dec, vsel, vhi, last, fire;
  logic [DW-1:0] wdata, off;
  fx_e  fx;

  // per-class micro-step decode
  always_comb begin
    acc_rd  = 1'b0;
    acc_wr  = 1'b0;
    off_dec = 1'b0;
    vsel    = 1'b0;
    vhi     = 1'b0;
    wdata   = '0;
    fx      = FX_HOLD;
    last    = 1'b0;
    unique case (op_q)
      OP_CLI: begin fx = FX_CLR_IF; last = 1'b1; end
      OP_STI: begin fx = FX_SET_IF; last = 1'b1; end
      OP_PUSHF: begin
        if (step_q != STEP_W'(0)) begin
          acc_wr = 1'b1;
          wdata  = flags_q[DW-1:0];
          last   = 1'b1;
        end
      end
      OP_POPF: begin
        if (step_q == STEP_W'(0)) begin
          acc_rd = 1'b1;
          fx     = FX_LOAD_LO;
        end else begin
          last = 1'b1;
        end
      end
      OP_INT: begin
        unique case (step_q)
          STEP_W'(1): begin acc_wr = 1'b1; off_dec = 1'b1; wdata = flags_q[DW-1:0]; end
          STEP_W'(2): begin acc_wr = 1'b1; off_dec = 1'b1; wdata = cs_q; end
          STEP_W'(3): begin acc_wr = 1'b1; off_dec = 1'b1; wdata = ip_q; end
          STEP_W'(4): begin acc_rd = 1'b1; vsel = 1'b1; end
          STEP_W'(5): begin acc_rd = 1'b1; vsel = 1'b1; vhi = 1'b1; end
          STEP_W'(6): begin fx = FX_ENTER_INT; last = 1'b1; end
          default: ;
        endcase
      end
      OP_IRET: begin
        acc_rd = 1'b1;
        if (step_q == STEP_W'(2)) begin
          fx   = FX_LOAD_USER;
          last = 1'b1;
        end
      end
      default: last = 1'b1;
    endcase
  end

  assign off  = off_dec ? sp_q - TWO : sp_q;
  assign fire = (st_q == ST_RUN) && (!(acc_rd || acc_wr) || mem_ack_i);

  v86_emu_agen #(.AW(AW), .DW(DW), .VW(VW)) u_agen (
    .seg_i  (ss_q),
    .off_i  (off),
    .vec_i  (vec_q),
    .vsel_i (vsel),
    .vhi_i  (vhi),
    .addr_o (mem_addr_o)
  );

  v86_emu_flagfix #(.FW(FW), .DW(DW)) u_flagfix (
    .mode_i  (fx),
    .flags_i (flags_q),
    .word_i  (mem_rdata_i),
    .flags_o (flags_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_NONE;
      vec_q   <= '0;
      step_q  <= '0;
      ss_q    <= '0;
      sp_q    <= '0;
      cs_q    <= '0;
      ip_q    <= '0;
      flags_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q    <= ST_RUN;
            op_q    <= op_e'(op_i);
            vec_q   <= vec_i;
            step_q  <= '0;
            ss_q    <= ss_i;
            sp_q    <= sp_i;
            cs_q    <= cs_i;
            ip_q    <= ip_i;
            flags_q <= flags_i;
          end
        end
        ST_RUN: begin
          if (fire) begin
            if (fx != FX_HOLD) flags_q <= flags_nxt;
            unique case (op_q)
              OP_CLI, OP_STI: ip_q <= ip_q + ONE;
              OP_PUSHF: begin
                if (step_q == STEP_W'(0)) sp_q <= sp_q - TWO;
                else                      ip_q <= ip_q + ONE;
              end
              OP_POPF: begin
                if (step_q != STEP_W'(0)) begin
                  sp_q <= sp_q + TWO;
                  ip_q <= ip_q + ONE;
                end
              end
              OP_INT: begin
                unique case (step_q)
                  STEP_W'(0): ip_q <= ip_q + TWO;
                  STEP_W'(1), STEP_W'(2), STEP_W'(3): sp_q <= sp_q - TWO;
                  STEP_W'(4): ip_q <= mem_rdata_i;
                  STEP_W'(5): cs_q <= mem_rdata_i;
                  default: ;
                endcase
              end
              OP_IRET: begin
                sp_q <= sp_q + TWO;
                if (step_q == STEP_W'(0)) ip_q <= mem_rdata_i;
                if (step_q == STEP_W'(1)) cs_q <= mem_rdata_i;
              end
              default: ;
            endcase
            step_q <= step_q + 1'b1;
            if (last) st_q <= ST_FIN;
          end
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_FIN);
  assign term_o      = done_o && (op_q == OP_HLT);
  assign mem_req_o   = (st_q == ST_RUN) && (acc_rd || acc_wr);
  assign mem_we_o    = (st_q == ST_RUN) && acc_wr;
  assign mem_wdata_o = wdata;
  assign sp_o        = sp_q;
  assign flags_o     = flags_q;
  assign cs_o        = cs_q;
  assign ip_o        = ip_q;
endmodule

// File: rtl/v86_emu_seq_chk.sv
module v86_emu_seq_chk #(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          term_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ack_i
);
  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                   && $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R10
  req_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (busy_o && !done_o));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  // R11
  busy_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R8
  term_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |-> done_o);

  // R12
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> !busy_o);
endmodule

bind v86_emu_seq v86_emu_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .term_o      (term_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/v86_emu_seq_bench.sv
module v86_emu_seq_bench;
  localparam time TCK = 8ns;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        start_i;
  logic [2:0]  op_i;
  logic [7:0]  vec_i;
  logic [15:0] ss_i, sp_i, cs_i, ip_i;
  logic [31:0] flags_i;
  logic        busy_o, done_o, term_o;
  logic [15:0] sp_o, cs_o, ip_o;
  logic [31:0] flags_o;
  logic        mem_req_o, mem_we_o, mem_ack_i;
  logic [19:0] mem_addr_o;
  logic [15:0] mem_wdata_o, mem_rdata_i;

  always #(TCK/2) clk = ~clk;

  v86_emu_seq u_v86_emu_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i), .vec_i(vec_i),
    .ss_i(ss_i), .sp_i(sp_i), .flags_i(flags_i), .cs_i(cs_i), .ip_i(ip_i),
    .busy_o(busy_o), .done_o(done_o), .term_o(term_o),
    .sp_o(sp_o), .flags_o(flags_o), .cs_o(cs_o), .ip_o(ip_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i)
  );

  int total = 0;
  int bad   = 0;

  logic [15:0] mem [int unsigned];

  typedef struct {
    logic        we;
    logic [19:0] addr;
    logic [15:0] data;
  } acc_t;
  acc_t expq[$];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] sa(input logic [15:0] s, input logic [15:0] o);
    return 20'({s, 4'b0000}) + 20'(o);
  endfunction

  function automatic logic [15:0] rd_mem(input logic [19:0] a);
    int unsigned k = 32'(a);
    if (mem.exists(k)) return mem[k];
    return 16'(k * 37 + 5);
  endfunction

  task automatic add_acc(input logic we, input logic [19:0] a, input logic [15:0] d);
    acc_t e;
    e.we = we; e.addr = a; e.data = d;
    expq.push_back(e);
  endtask

  task automatic run_op(input string req, input logic [2:0] op, input logic [7:0] vec,
                        input logic [15:0] ss, input logic [15:0] sp, input logic [31:0] fl,
                        input logic [15:0] cs, input logic [15:0] ip,
                        input int lat, input bit intrude);
    logic [15:0] e_sp = sp, e_ip = ip, e_cs = cs, w, t;
    logic [31:0] e_fl = fl;
    logic        e_term = 1'b0;
    int          wait_c = lat;
    int          guard  = 0;
    expq.delete();
    case (op)
      3'd0: begin e_fl[9] = 1'b0; e_ip = ip + 16'd1; end
      3'd1: begin e_fl[9] = 1'b1; e_ip = ip + 16'd1; end
      3'd2: begin
        e_sp = sp - 16'd2;
        add_acc(1'b1, sa(ss, e_sp), fl[15:0]);
        e_ip = ip + 16'd1;
      end
      3'd3: begin
        w = rd_mem(sa(ss, sp));
        add_acc(1'b0, sa(ss, sp), w);
        e_fl[15:0] = w;
        e_sp = sp + 16'd2;
        e_ip = ip + 16'd1;
      end
      3'd4: begin
        t = ip + 16'd2;
        add_acc(1'b1, sa(ss, sp - 16'd2), fl[15:0]);
        add_acc(1'b1, sa(ss, sp - 16'd4), cs);
        add_acc(1'b1, sa(ss, sp - 16'd6), t);
        e_sp = sp - 16'd6;
        e_ip = rd_mem(20'({vec, 2'b00}));
        add_acc(1'b0, 20'({vec, 2'b00}), e_ip);
        e_cs = rd_mem(20'({vec, 2'b10}));
        add_acc(1'b0, 20'({vec, 2'b10}), e_cs);
        e_fl[9] = 1'b0;
        e_fl[8] = 1'b0;
      end
      3'd5: begin
        e_ip = rd_mem(sa(ss, sp));
        add_acc(1'b0, sa(ss, sp), e_ip);
        e_cs = rd_mem(sa(ss, sp + 16'd2));
        add_acc(1'b0, sa(ss, sp + 16'd2), e_cs);
        w = rd_mem(sa(ss, sp + 16'd4));
        add_acc(1'b0, sa(ss, sp + 16'd4), w);
        e_fl[15:0]  = w;
        e_fl[13:12] = fl[13:12];
        e_sp = sp + 16'd6;
      end
      3'd6: e_term = 1'b1;
      default: ;
    endcase

    @(negedge clk);
    start_i = 1'b1; op_i = op; vec_i = vec;
    ss_i = ss; sp_i = sp; flags_i = fl; cs_i = cs; ip_i = ip;
    @(negedge clk);
    start_i = intrude;
    if (intrude) begin
      op_i = 3'd1; vec_i = ~vec;
      ss_i = ~ss; sp_i = ~sp; flags_i = ~fl; cs_i = ~cs; ip_i = ~ip;
    end
    chk("R11", "busy after start", 32'(busy_o), 32'd1);
    while (!done_o && guard < 200) begin
      if (mem_req_o) begin
        if (wait_c == 0) begin
          if (expq.size() == 0) begin
            chk("R10", "unexpected access", 32'(mem_addr_o), 32'hFFFFFFFF);
          end else begin
            acc_t e = expq.pop_front();
            chk(req, "access dir",  32'(mem_we_o),   32'(e.we));
            chk(req, "access addr", 32'(mem_addr_o), 32'(e.addr));
            if (e.we) begin
              chk(req, "write data", 32'(mem_wdata_o), 32'(e.data));
              mem[32'(mem_addr_o)] = mem_wdata_o;
            end
          end
          mem_rdata_i = rd_mem(mem_addr_o);
          mem_ack_i   = 1'b1;
          wait_c      = lat;
        end else begin
          mem_ack_i = 1'b0;
          wait_c--;
        end
      end else begin
        mem_ack_i = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    mem_ack_i = 1'b0;
    // start in the done cycle must also be ignored (R12)
    start_i = intrude;
    chk(req, "done seen", 32'(done_o), 32'd1);
    chk("R10", "accesses left", 32'(expq.size()), 32'd0);
    chk(req, "sp",    32'(sp_o), 32'(e_sp));
    chk(req, "ip",    32'(ip_o), 32'(e_ip));
    chk(req, "cs",    32'(cs_o), 32'(e_cs));
    chk(req, "flags", flags_o,   e_fl);
    chk(req, "term",  32'(term_o), 32'(e_term));
    @(negedge clk);
    start_i = 1'b0;
    chk("R11", "done one cycle", 32'(done_o), 32'd0);
    chk("R12", "idle after done", 32'(busy_o), 32'd0);
    if (intrude) begin
      chk("R12", "frame kept sp", 32'(sp_o), 32'(e_sp));
      chk("R12", "frame kept flags", flags_o, e_fl);
    end
    @(negedge clk);
    chk("R12", "still idle", 32'(busy_o), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; op_i = '0; vec_i = '0;
    ss_i = '0; sp_i = '0; flags_i = '0; cs_i = '0; ip_i = '0;
    mem_ack_i = 1'b0; mem_rdata_i = '0;
    repeat (3) @(negedge clk);
    chk("R1", "busy", 32'(busy_o), 32'd0);
    chk("R1", "done", 32'(done_o), 32'd0);
    chk("R1", "term", 32'(term_o), 32'd0);
    chk("R1", "req",  32'(mem_req_o), 32'd0);
    chk("R1", "flags", flags_o, 32'd0);
    chk("R1", "sp", 32'(sp_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2
    run_op("R2", 3'd0, 8'h00, 16'h1000, 16'h0200, 32'h0002_3302, 16'h4000, 16'h0010, 0, 1'b0);
    run_op("R2", 3'd1, 8'h00, 16'h1000, 16'h0200, 32'h0002_3002, 16'h4000, 16'hFFFF, 0, 1'b0);
    // R3
    run_op("R3", 3'd2, 8'h00, 16'h2000, 16'h0100, 32'h0002_0A57, 16'h3000, 16'h0040, 1, 1'b0);
    // R9: offset wraps below zero
    run_op("R9", 3'd2, 8'h00, 16'hFFFF, 16'h0000, 32'h0000_1234, 16'h3000, 16'h0041, 0, 1'b0);
    // R4
    mem[32'(sa(16'h2000, 16'h00FE))] = 16'h0C81;
    run_op("R4", 3'd3, 8'h00, 16'h2000, 16'h00FE, 32'hABCD_3202, 16'h3000, 16'h0050, 2, 1'b0);
    // R5 / R6
    mem[32'h70] = 16'hFF53;
    mem[32'h72] = 16'hF000;
    run_op("R5", 3'd4, 8'h1C, 16'h2000, 16'h0400, 32'h0002_3346, 16'h1234, 16'h0100, 0, 1'b0);
    // R6 with top vector and R9 with 20-bit truncation
    run_op("R6", 3'd4, 8'hFF, 16'hFFFF, 16'h0024, 32'h0002_0302, 16'h5555, 16'hFFFF, 2, 1'b0);
    // R7
    mem[32'(sa(16'h2000, 16'h0300))] = 16'h0123;
    mem[32'(sa(16'h2000, 16'h0302))] = 16'h0456;
    mem[32'(sa(16'h2000, 16'h0304))] = 16'h0EC7;
    run_op("R7", 3'd5, 8'h00, 16'h2000, 16'h0300, 32'h0002_3202, 16'h1111, 16'h2222, 1, 1'b0);
    // R8
    run_op("R8", 3'd6, 8'h00, 16'h2000, 16'h0300, 32'h0002_3202, 16'h1111, 16'h2222, 0, 1'b0);
    run_op("R8", 3'd7, 8'h00, 16'h2000, 16'h0300, 32'h0002_3202, 16'h1111, 16'h2222, 0, 1'b0);
    // R12: start pulses during the run and in the done cycle
    run_op("R12", 3'd2, 8'h00, 16'h0800, 16'h0010, 32'h0002_0246, 16'h0900, 16'h0077, 2, 1'b1);
    run_op("R12", 3'd4, 8'h08, 16'h0800, 16'h0010, 32'h0002_0346, 16'h0900, 16'h0078, 1, 1'b1);
    // R10: back-to-back accesses with zero latency
    run_op("R10", 3'd5, 8'h00, 16'h0800, 16'hFFFC, 32'h0000_1000, 16'h0900, 16'h0079, 0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule